// File: doc/BRIEF.md
# Gated Event Counter with Programmable Limits

This block is one counting channel. It counts rising edges on an event input, but only while its internal gate is open. The internal gate opens when a software gate and a hardware gate are both open, and a reconfiguration has not locked it. The count moves between a programmable low and high limit and wraps at either end. A wrap sets a sticky underflow or overflow flag. Two comparison values raise sticky event flags when the count steps onto them. A status output is high while the count is at or above the first comparison value.

Software changes the limits, the start value, the comparison values or the count through a single request slot. The slot carries a code and a data word. A request is applied only if the resulting settings stay consistent. A request that is applied inverts an acknowledge bit. A request that is refused sets a latching error bit and changes nothing. A reconfiguration strobe latches the count direction and puts the count back to the start value. It also holds the gate closed until the software gate has been seen closed and then opened again.

Top module: `gated_counter`

## Requirements
- R1: The gate status output `gateSts` equals `swGate & hwGate & !lock`, where `lock` is the reconfiguration lock. No event edge changes the count while `gateSts` is 0.
- R2: While the gate is open, each rising edge of `evtIn` changes the count by one. An edge is `evtIn` at 1 in a cycle after a cycle at 0. The count goes up when the latched direction is 0 and down when it is 1.
- R3: Counting up from the high limit wraps the count to the low limit and sets `oflwFlag`. Counting down from the low limit wraps the count to the high limit and sets `uflwFlag`.
- R4: `uflwFlag`, `oflwFlag`, `cmp0Flag` and `cmp1Flag` stay set until their own acknowledge input is high at a clock edge. A new set in the same cycle wins over the acknowledge.
- R5: `cmp0Flag` (`cmp1Flag`) is set when a counting step lands the count on comparison value 0 (1). A load or a reconfiguration that puts the count on that value never sets the flag.
- R6: `dqOut` is 1 exactly when the count is greater than or equal to comparison value 0.
- R7: `ldCode` selects the target of a request. The codes are 1 for the count, 2 for the start value, 3 for comparison value 0, 4 for comparison value 1, 5 for the low limit and 6 for the high limit. A valid request updates that target at the clock edge and inverts `ldAck`. A request in a cycle stops any count step in that cycle.
- R8: A request is refused under any of these conditions. A refused request sets `ldErr`, leaves every setting and the count unchanged, and does not invert `ldAck`.
  - The code is 0 or 7.
  - A count load lies outside the low and high limits.
  - The resulting settings break any of low ≤ start ≤ high, low ≤ cmp0, cmp1 ≤ high, low < high or cmp0 < cmp1.
- R9: A valid low-limit or high-limit load that leaves the current count outside the new limits also sets the count to the start value.
- R10: `ldErr` stays at 1 until `ackErr` is high at a clock edge. A refusal in the same cycle wins.
- R11: A `cfgWrite` pulse latches `cfgDown` as the direction and sets the count to the start value. It locks the gate closed until `swGate` has been seen at 0. It takes priority over a request in the same cycle.
- R12: A synchronous reset sets the count to the start value and all flags, `ldAck` and `ldErr` to 0. It sets the direction to up, clears the lock and restores the default settings: low 10, high 200, start 50, cmp0 60, cmp1 120.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| swGate | input | 1 | Software gate, 1 = open |
| hwGate | input | 1 | Hardware gate, 1 = open |
| evtIn | input | 1 | Event input; rising edges are counted |
| cfgWrite | input | 1 | Reconfiguration strobe |
| cfgDown | input | 1 | Direction taken at cfgWrite, 1 = down |
| ldReq | input | 1 | Load request strobe |
| ldCode | input | 3 | Load target code |
| ldData | input | CNT_W | Load value |
| ackUflw | input | 1 | Clears the underflow flag |
| ackOflw | input | 1 | Clears the overflow flag |
| ackCmp0 | input | 1 | Clears the comparison-0 flag |
| ackCmp1 | input | 1 | Clears the comparison-1 flag |
| ackErr | input | 1 | Clears the load-error bit |
| count | output | CNT_W | Current count |
| gateSts | output | 1 | Internal gate state |
| dqOut | output | 1 | Count at or above comparison value 0 |
| uflwFlag | output | 1 | Sticky underflow |
| oflwFlag | output | 1 | Sticky overflow |
| cmp0Flag | output | 1 | Sticky comparison-0 event |
| cmp1Flag | output | 1 | Sticky comparison-1 event |
| ldAck | output | 1 | Toggles on each applied load |
| ldErr | output | 1 | Latched load refusal |

## Verification
The range and ordering assertions assume the reset defaults form a consistent set. They also assume that only validated requests, wraps and start-value reloads ever move the count or the settings. The stimulus never drives anything that bypasses the request slot, so those invariants must hold from reset on. Random request data is drawn half from the whole range and half from inside the current limits. This gives a real mix of accepted and refused loads, including the reserved codes. The gates, the acknowledges and reconfiguration are toggled at rates that leave long counting stretches between them.

// File: rtl/gcnt_pkg.sv
package gcnt_pkg;

  typedef enum logic [2:0] {
    LD_NONE  = 3'd0,
    LD_COUNT = 3'd1,
    LD_START = 3'd2,
    LD_CMP0  = 3'd3,
    LD_CMP1  = 3'd4,
    LD_LOW   = 3'd5,
    LD_HIGH  = 3'd6,
    LD_RSVD  = 3'd7
  } ldCode_e;

  // strobes from control to datapath, at most one of step/load/reinit high
  typedef struct packed {
    logic    step;
    logic    load;
    logic    reinit;
    ldCode_e code;
  } gcntStrobe_t;

endpackage

// File: rtl/gcnt_ctrl.sv
module gcnt_ctrl
  import gcnt_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             swGate,
  input  logic             hwGate,
  input  logic             evtIn,
  input  logic             cfgWrite,
  input  logic             ldReq,
  input  logic [2:0]       ldCode,
  input  logic [CNT_W-1:0] ldData,
  input  logic             ackErr,
  input  logic [CNT_W-1:0] curLow,
  input  logic [CNT_W-1:0] curHigh,
  input  logic [CNT_W-1:0] curStart,
  input  logic [CNT_W-1:0] curCmp0,
  input  logic [CNT_W-1:0] curCmp1,
  output gcntStrobe_t      st,
  output logic             gateOpen,
  output logic             ldAck,
  output logic             ldErr
);

  logic evtPrev;
  logic gateLock;
  logic evtRise;
  logic reqValid;
  logic paramOk;
  logic countOk;
  ldCode_e code;
  logic [CNT_W-1:0] candLow, candHigh, candStart, candCmp0, candCmp1;

  assign code     = ldCode_e'(ldCode);
  assign evtRise  = evtIn && !evtPrev;
  assign gateOpen = swGate && hwGate && !gateLock;

  // candidate settings as they would be after the request
  always_comb begin
    candLow   = curLow;
    candHigh  = curHigh;
    candStart = curStart;
    candCmp0  = curCmp0;
    candCmp1  = curCmp1;
    case (code)
      LD_START: candStart = ldData;
      LD_CMP0:  candCmp0  = ldData;
      LD_CMP1:  candCmp1  = ldData;
      LD_LOW:   candLow   = ldData;
      LD_HIGH:  candHigh  = ldData;
      default:  ;
    endcase
  end

  assign paramOk = (candLow <= candStart) && (candStart <= candHigh) &&
                   (candLow <= candCmp0) && (candCmp1 <= candHigh) &&
                   (candLow < candHigh) && (candCmp0 < candCmp1);
  assign countOk = (ldData >= curLow) && (ldData <= curHigh);

  always_comb begin
    case (code)
      LD_COUNT:                                    reqValid = countOk;
      LD_START, LD_CMP0, LD_CMP1, LD_LOW, LD_HIGH: reqValid = paramOk;
      default:                                     reqValid = 1'b0;
    endcase
  end

  always_comb begin
    st.reinit = cfgWrite;
    st.load   = !cfgWrite && ldReq && reqValid;
    st.step   = !cfgWrite && !ldReq && gateOpen && evtRise;
    st.code   = code;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evtPrev  <= 1'b0;
      gateLock <= 1'b0;
      ldAck    <= 1'b0;
      ldErr    <= 1'b0;
    end else begin
      evtPrev <= evtIn;
      if (cfgWrite)     gateLock <= 1'b1;
      else if (!swGate) gateLock <= 1'b0;
      if (st.load) ldAck <= !ldAck;
      if (ackErr)  ldErr <= 1'b0;
      if (!cfgWrite && ldReq && !reqValid) ldErr <= 1'b1;
    end
  end

  AST_REJECT_LATCH: assert property (@(posedge clk) disable iff (rst)
    (ldReq && !cfgWrite && !reqValid) |=> (ldErr && $stable(ldAck))) // R8
    else $error("refused request did not latch error");

  AST_RECONF_LOCK: assert property (@(posedge clk) disable iff (rst)
    cfgWrite |=> !gateOpen) // R11
    else $error("gate open right after reconfiguration");

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $countones({st.step, st.load, st.reinit}) <= 1) // R7
    else $error("more than one datapath strobe");

endmodule

// File: rtl/gcnt_datapath.sv
module gcnt_datapath
  import gcnt_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned LOW_INIT   = 10,
  parameter int unsigned HIGH_INIT  = 200,
  parameter int unsigned START_INIT = 50,
  parameter int unsigned CMP0_INIT  = 60,
  parameter int unsigned CMP1_INIT  = 120
) (
  input  logic             clk,
  input  logic             rst,
  input  gcntStrobe_t      st,
  input  logic             cfgDown,
  input  logic [CNT_W-1:0] ldData,
  input  logic             ackUflw,
  input  logic             ackOflw,
  input  logic             ackCmp0,
  input  logic             ackCmp1,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] lowLim,
  output logic [CNT_W-1:0] highLim,
  output logic [CNT_W-1:0] startVal,
  output logic [CNT_W-1:0] cmp0Val,
  output logic [CNT_W-1:0] cmp1Val,
  output logic             uflwFlag,
  output logic             oflwFlag,
  output logic             cmp0Flag,
  output logic             cmp1Flag,
  output logic             dqOut
);

  localparam logic [CNT_W-1:0] LowRst   = CNT_W'(LOW_INIT);
  localparam logic [CNT_W-1:0] HighRst  = CNT_W'(HIGH_INIT);
  localparam logic [CNT_W-1:0] StartRst = CNT_W'(START_INIT);
  localparam logic [CNT_W-1:0] Cmp0Rst  = CNT_W'(CMP0_INIT);
  localparam logic [CNT_W-1:0] Cmp1Rst  = CNT_W'(CMP1_INIT);

  logic             dirDown;
  logic             wrapUp;
  logic             wrapDown;
  logic [CNT_W-1:0] nextCount;

  assign wrapUp   = !dirDown && (count == highLim);
  assign wrapDown =  dirDown && (count == lowLim);

  always_comb begin
    if (wrapUp)       nextCount = lowLim;
    else if (wrapDown) nextCount = highLim;
    else if (dirDown) nextCount = count - 1'b1;
    else              nextCount = count + 1'b1;
  end

  assign dqOut = (count >= cmp0Val);

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= StartRst;
      lowLim   <= LowRst;
      highLim  <= HighRst;
      startVal <= StartRst;
      cmp0Val  <= Cmp0Rst;
      cmp1Val  <= Cmp1Rst;
      dirDown  <= 1'b0;
      uflwFlag <= 1'b0;
      oflwFlag <= 1'b0;
      cmp0Flag <= 1'b0;
      cmp1Flag <= 1'b0;
    end else begin
      if (ackUflw) uflwFlag <= 1'b0;
      if (ackOflw) oflwFlag <= 1'b0;
      if (ackCmp0) cmp0Flag <= 1'b0;
      if (ackCmp1) cmp1Flag <= 1'b0;
      if (st.reinit) begin
        count   <= startVal;
        dirDown <= cfgDown;
      end else if (st.load) begin
        case (st.code)
          LD_COUNT: count    <= ldData;
          LD_START: startVal <= ldData;
          LD_CMP0:  cmp0Val  <= ldData;
          LD_CMP1:  cmp1Val  <= ldData;
          LD_LOW: begin
            lowLim <= ldData;
            if ((count < ldData) || (count > highLim)) count <= startVal;
          end
          LD_HIGH: begin
            highLim <= ldData;
            if ((count < lowLim) || (count > ldData)) count <= startVal;
          end
          default: ;
        endcase
      end else if (st.step) begin
        count <= nextCount;
        if (wrapUp)               oflwFlag <= 1'b1;
        if (wrapDown)             uflwFlag <= 1'b1;
        if (nextCount == cmp0Val) cmp0Flag <= 1'b1;
        if (nextCount == cmp1Val) cmp1Flag <= 1'b1;
      end
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!st.step && !st.load && !st.reinit) |=> $stable(count)) // R1
    else $error("count moved without a strobe");

  AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (st.step && !dirDown && count == highLim) |=> (count == $past(lowLim) && oflwFlag)) // R3
    else $error("up wrap wrong");

  AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (rst)
    (st.step && dirDown && count == lowLim) |=> (count == $past(highLim) && uflwFlag)) // R3
    else $error("down wrap wrong");

  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (count >= lowLim) && (count <= highLim)) // R9
    else $error("count outside limits");

  AST_SETTINGS_ORDER: assert property (@(posedge clk) disable iff (rst)
    (lowLim < highLim) && (cmp0Val < cmp1Val) && (lowLim <= startVal) && (startVal <= highLim)) // R8
    else $error("settings inconsistent");

  AST_REINIT_NO_CMP: assert property (@(posedge clk) disable iff (rst)
    st.reinit |=> (!$rose(cmp0Flag) && !$rose(cmp1Flag))) // R5
    else $error("reconfiguration raised a comparison flag");

endmodule

// File: rtl/gated_counter.sv
module gated_counter
  import gcnt_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned LOW_INIT   = 10,
  parameter int unsigned HIGH_INIT  = 200,
  parameter int unsigned START_INIT = 50,
  parameter int unsigned CMP0_INIT  = 60,
  parameter int unsigned CMP1_INIT  = 120
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             swGate,
  input  logic             hwGate,
  input  logic             evtIn,
  input  logic             cfgWrite,
  input  logic             cfgDown,
  input  logic             ldReq,
  input  logic [2:0]       ldCode,
  input  logic [CNT_W-1:0] ldData,
  input  logic             ackUflw,
  input  logic             ackOflw,
  input  logic             ackCmp0,
  input  logic             ackCmp1,
  input  logic             ackErr,
  output logic [CNT_W-1:0] count,
  output logic             gateSts,
  output logic             dqOut,
  output logic             uflwFlag,
  output logic             oflwFlag,
  output logic             cmp0Flag,
  output logic             cmp1Flag,
  output logic             ldAck,
  output logic             ldErr
);

  gcntStrobe_t      strobe;
  logic [CNT_W-1:0] lowLim, highLim, startVal, cmp0Val, cmp1Val;

  gcnt_ctrl #(.CNT_W(CNT_W)) ctrlInst (
    .clk      (clk),
    .rst      (rst),
    .swGate   (swGate),
    .hwGate   (hwGate),
    .evtIn    (evtIn),
    .cfgWrite (cfgWrite),
    .ldReq    (ldReq),
    .ldCode   (ldCode),
    .ldData   (ldData),
    .ackErr   (ackErr),
    .curLow   (lowLim),
    .curHigh  (highLim),
    .curStart (startVal),
    .curCmp0  (cmp0Val),
    .curCmp1  (cmp1Val),
    .st       (strobe),
    .gateOpen (gateSts),
    .ldAck    (ldAck),
    .ldErr    (ldErr)
  );

  gcnt_datapath #(
    .CNT_W(CNT_W), .LOW_INIT(LOW_INIT), .HIGH_INIT(HIGH_INIT),
    .START_INIT(START_INIT), .CMP0_INIT(CMP0_INIT), .CMP1_INIT(CMP1_INIT)
  ) dpInst (
    .clk      (clk),
    .rst      (rst),
    .st       (strobe),
    .cfgDown  (cfgDown),
    .ldData   (ldData),
    .ackUflw  (ackUflw),
    .ackOflw  (ackOflw),
    .ackCmp0  (ackCmp0),
    .ackCmp1  (ackCmp1),
    .count    (count),
    .lowLim   (lowLim),
    .highLim  (highLim),
    .startVal (startVal),
    .cmp0Val  (cmp0Val),
    .cmp1Val  (cmp1Val),
    .uflwFlag (uflwFlag),
    .oflwFlag (oflwFlag),
    .cmp0Flag (cmp0Flag),
    .cmp1Flag (cmp1Flag),
    .dqOut    (dqOut)
  );

endmodule

// File: tb/gated_counter_test.sv
module gated_counter_test;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic swGate = 0, hwGate = 0, evtIn = 0, cfgWrite = 0, cfgDown = 0, ldReq = 0;
  logic [2:0] ldCode = 0;
  logic [W-1:0] ldData = 0;
  logic ackUflw = 0, ackOflw = 0, ackCmp0 = 0, ackCmp1 = 0, ackErr = 0;
  logic [W-1:0] count;
  logic gateSts, dqOut, uflwFlag, oflwFlag, cmp0Flag, cmp1Flag, ldAck, ldErr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  logic [W-1:0] mCount, mLow, mHigh, mStart, mC0, mC1;
  logic mDown, mLock, mPrev, mUf, mOf, mC0f, mC1f, mAck, mErr;

  always #5 clk = ~clk;

  gated_counter uut (
    .clk(clk), .rst(rst), .swGate(swGate), .hwGate(hwGate), .evtIn(evtIn),
    .cfgWrite(cfgWrite), .cfgDown(cfgDown), .ldReq(ldReq), .ldCode(ldCode),
    .ldData(ldData), .ackUflw(ackUflw), .ackOflw(ackOflw), .ackCmp0(ackCmp0),
    .ackCmp1(ackCmp1), .ackErr(ackErr), .count(count), .gateSts(gateSts),
    .dqOut(dqOut), .uflwFlag(uflwFlag), .oflwFlag(oflwFlag), .cmp0Flag(cmp0Flag),
    .cmp1Flag(cmp1Flag), .ldAck(ldAck), .ldErr(ldErr)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit loadOk(input logic [2:0] c, input logic [W-1:0] d);
    int lo, hi, s, a, b;
    lo = mLow; hi = mHigh; s = mStart; a = mC0; b = mC1;
    if (c == 3'd1) return (d >= mLow) && (d <= mHigh);
    if (c == 3'd0 || c == 3'd7) return 1'b0;
    if (c == 3'd2) s = d;
    if (c == 3'd3) a = d;
    if (c == 3'd4) b = d;
    if (c == 3'd5) lo = d;
    if (c == 3'd6) hi = d;
    return (lo < hi) && (a < b) && (s >= lo) && (s <= hi) && (a >= lo) && (b <= hi);
  endfunction

  task automatic modelEdge();
    logic rise, gate;
    if (rst) begin
      mCount = 50; mLow = 10; mHigh = 200; mStart = 50; mC0 = 60; mC1 = 120;
      mDown = 0; mLock = 0; mPrev = 0; mUf = 0; mOf = 0; mC0f = 0; mC1f = 0;
      mAck = 0; mErr = 0;
    end else begin
      rise = evtIn && !mPrev;
      gate = swGate && hwGate && !mLock;
      mPrev = evtIn;
      if (ackUflw) mUf = 0;
      if (ackOflw) mOf = 0;
      if (ackCmp0) mC0f = 0;
      if (ackCmp1) mC1f = 0;
      if (ackErr)  mErr = 0;
      if (cfgWrite) begin
        mDown = cfgDown;
        mCount = mStart;
      end else if (ldReq) begin
        if (loadOk(ldCode, ldData)) begin
          case (ldCode)
            3'd1: mCount = ldData;
            3'd2: mStart = ldData;
            3'd3: mC0 = ldData;
            3'd4: mC1 = ldData;
            3'd5: mLow = ldData;
            default: mHigh = ldData;
          endcase
          if (mCount < mLow || mCount > mHigh) mCount = mStart;
          mAck = !mAck;
        end else mErr = 1;
      end else if (gate && rise) begin
        if (!mDown) begin
          if (mCount == mHigh) begin mCount = mLow; mOf = 1; end
          else mCount = mCount + 1;
        end else begin
          if (mCount == mLow) begin mCount = mHigh; mUf = 1; end
          else mCount = mCount - 1;
        end
        if (mCount == mC0) mC0f = 1;
        if (mCount == mC1) mC1f = 1;
      end
      if (cfgWrite) mLock = 1;
      else if (!swGate) mLock = 0;
    end
  endtask

  task automatic compareAll();
    chk("R1 gateSts", gateSts, int'(swGate && hwGate && !mLock));
    chk("R2 count", count, mCount);
    chk("R3 oflwFlag", oflwFlag, mOf);
    chk("R3 uflwFlag", uflwFlag, mUf);
    chk("R5 cmp0Flag", cmp0Flag, mC0f);
    chk("R5 cmp1Flag", cmp1Flag, mC1f);
    chk("R6 dqOut", dqOut, int'(mCount >= mC0));
    chk("R7 ldAck", ldAck, mAck);
    chk("R8 ldErr", ldErr, mErr);
  endtask

  // one clock: inputs already driven, sample 1 ns after the edge, return at negedge
  task automatic clk1();
    @(posedge clk);
    #1;
    modelEdge();
    compareAll();
    @(negedge clk);
  endtask

  task automatic pulse();
    evtIn = 1; clk1();
    evtIn = 0; clk1();
  endtask

  task automatic load(input int c, input int d);
    ldReq = 1; ldCode = 3'(c); ldData = W'(d);
    clk1();
    ldReq = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    rst = 1; clk1(); clk1();
    rst = 0; clk1();
    // R12 reset state
    chk("R12 count after reset", count, 50);
    chk("R12 ldErr after reset", ldErr, 0);
    chk("R12 flags after reset", {uflwFlag, oflwFlag, cmp0Flag, cmp1Flag, ldAck}, 0);
    chk("R1 gate closed with swGate=0", gateSts, 0);
    swGate = 1; hwGate = 1; clk1();
    chk("R1 gate open", gateSts, 1);
    pulse();
    chk("R2 up by one", count, 51);
    hwGate = 0; pulse();
    chk("R1 hw gate closed blocks count", count, 51);
    hwGate = 1;
    load(1, 199);
    chk("R7 count load", count, 199);
    chk("R7 ack toggled", ldAck, 1);
    pulse(); pulse();
    chk("R3 up wrap to low", count, 10);
    chk("R3 overflow set", oflwFlag, 1);
    ackOflw = 1; clk1(); ackOflw = 0;
    chk("R4 overflow cleared by ack", oflwFlag, 0);
    load(3, 5);
    chk("R8 cmp0 below low refused", ldErr, 1);
    chk("R8 ack not toggled", ldAck, 1);
    chk("R8 nothing changed", dqOut, 0);
    clk1();
    chk("R10 error holds", ldErr, 1);
    ackErr = 1; clk1(); ackErr = 0;
    chk("R10 error cleared", ldErr, 0);
    load(7, 30);
    chk("R8 reserved code refused", ldErr, 1);
    ackErr = 1; clk1(); ackErr = 0;
    cfgWrite = 1; cfgDown = 1; clk1(); cfgWrite = 0;
    chk("R11 count to start", count, 50);
    chk("R11 gate locked", gateSts, 0);
    pulse();
    chk("R11 locked gate blocks count", count, 50);
    swGate = 0; clk1(); swGate = 1; clk1();
    chk("R11 gate reopened", gateSts, 1);
    pulse();
    chk("R2 down by one", count, 49);
    load(1, 15);
    load(5, 20);
    chk("R9 low load moves count to start", count, 50);
    load(1, 20);
    pulse();
    chk("R3 down wrap to high", count, 200);
    chk("R3 underflow set", uflwFlag, 1);
    load(1, 61);
    pulse();
    chk("R5 cmp0 event", cmp0Flag, 1);
    chk("R6 dq at cmp0", dqOut, 1);
    pulse();
    chk("R6 dq below cmp0", dqOut, 0);
    load(1, 120);
    chk("R5 load onto cmp1 sets nothing", cmp1Flag, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      swGate  = ($urandom % 16) != 0;
      hwGate  = ($urandom % 8) != 0;
      evtIn   = $urandom % 2;
      cfgWrite = ($urandom % 64) == 0;
      cfgDown = $urandom % 2;
      ldReq   = ($urandom % 12) == 0;
      ldCode  = 3'($urandom % 8);
      if ($urandom % 2) ldData = W'($urandom % 256);
      else ldData = W'(int'(mLow) + int'($urandom % (int'(mHigh) - int'(mLow) + 1)));
      ackUflw = ($urandom % 10) == 0;
      ackOflw = ($urandom % 10) == 0;
      ackCmp0 = ($urandom % 10) == 0;
      ackCmp1 = ($urandom % 10) == 0;
      ackErr  = ($urandom % 10) == 0;
      clk1();
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule